// File: doc/BRIEF.md
# Queue-Fed SPI Mode-0 Master

This block is an SPI master fixed to clock polarity 0 and clock phase 0. The system clock runs at four times the bit rate, so every bit occupies four system clocks. The host writes bytes into a four-entry transmit queue through a valid/ready port. The block shifts each byte out on MOSI, most significant bit first. At the same time it shifts in the byte arriving on MISO and places it in a four-entry receive queue, which the host drains through a second valid/ready port.

Chip select is handled without host involvement, based only on how full the transmit queue is:

- **Before a transfer:** chip select has been high for at least two clocks, and it falls once a byte is available.
- **During a transfer:** it stays low while the queue keeps supplying bytes, and consecutive bytes follow each other with no idle clocks.
- **When the queue runs dry:** after a byte finishes, SCK stays low for a two-clock back porch before chip select rises again.
- **When the receive queue is full:** if a byte completes while the receive queue is full, the engine parks with SCK low and chip select still low until the host frees an entry.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, cs_no=1, sck_o=0, mosi_o=0, busy_o=0, tx_ready_o=1 and rx_valid_o=0.
- R2: Each bit lasts 4 clocks: sck_o is low for the first 2 and high for the last 2; sck_o is never high while cs_no=1.
- R3: Bytes go out on mosi_o bit 7 first, and mosi_o holds the current bit for all 4 clocks of that bit; mosi_o is 0 while no bit is being shifted.
- R4: miso_i is sampled on the first clock of each bit on which sck_o is high. Bit 7 is received first. The completed byte is written to the receive queue at the end of its eighth bit.
- R5: Chip select stays high for at least 2 clocks after reset and after every release before it falls again. After that it falls on the clock after the transmit queue becomes non-empty.
- R6: When the transmit queue is non-empty at the end of a byte, the next byte's first bit begins on the very next clock with cs_no held low. n back-to-back bytes keep cs_no low for 32*n+2 clocks.
- R7: When the transmit queue is empty at the end of a byte, sck_o stays low and cs_no stays low for 2 further clocks, then cs_no rises.
- R8: The transmit queue holds 4 bytes. tx_ready_o is 0 only while 4 bytes are held. A write presented while tx_ready_o=0 is dropped and never transmitted.
- R9: If the receive queue holds 4 bytes when a byte completes, the engine holds sck_o=0 and cs_no=0 until an entry is read. It then stores the byte and continues.
- R10: The receive queue presents bytes in arrival order. rx_valid_o is 1 while it is non-empty, and an entry is removed on a clock where rx_valid_o and rx_ready_i are both 1.
- R11: busy_o is 1 on exactly the clocks where cs_no is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 4x the SPI bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | Host offers a transmit byte |
| tx_data_i | input | 8 | Transmit byte |
| tx_ready_o | output | 1 | Transmit queue can accept a byte |
| rx_valid_o | output | 1 | Receive queue holds a byte |
| rx_data_o | output | 8 | Oldest received byte |
| rx_ready_i | input | 1 | Host takes the received byte |
| sck_o | output | 1 | SPI serial clock, idles low |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| cs_no | output | 1 | Active-low chip select |
| busy_o | output | 1 | Chip select is asserted |

## Verification
Properties evaluated on every clock cover several rules:
- SCK stays low while the slave is deselected.
- MOSI holds steady across the high half of a bit.
- Chip select stays high for a second clock after each release.
- SCK is low on the clock before chip select rises.
- A stalled engine keeps SCK low with chip select held.
- The engine never pops an empty transmit queue.

Some behaviour can only be shown by the bench's scenarios, because it needs a reference byte stream: MSB-first data order, the exact MISO sampling clock, dropped writes to a full queue, the run lengths of chip select over one or several bytes, and the byte order out of the receive queue. The bench drives MISO from a pseudo-random sequence that changes every clock, so sampling on any clock other than the first high one yields different received bytes.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  typedef enum logic [2:0] {
    ST_GAP,    // deselected, minimum high time
    ST_IDLE,   // deselected, waiting for data
    ST_BIT,    // shifting
    ST_STALL,  // byte done, rx queue full
    ST_BACK    // back porch before release
  } sfm_state_e;
endpackage

// File: rtl/sfm_fifo.sv
module sfm_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic             wr_ready_o,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             rd_ready_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_en, rd_en;

  assign wr_ready_o = (cnt_q != CNT_W'(DEPTH));
  assign rd_valid_o = (cnt_q != '0);
  assign rd_data_o  = mem_q[rptr_q];
  assign wr_en      = wr_valid_i && wr_ready_o;
  assign rd_en      = rd_ready_i && rd_valid_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wptr_q <= nxt(wptr_q);
      if (rd_en) rptr_q <= nxt(rptr_q);
      if (wr_en && !rd_en)      cnt_q <= cnt_q + 1'b1;
      else if (rd_en && !wr_en) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wptr_q] <= wr_data_i;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ready_o && !(rd_ready_i && rd_valid_o)) |=> !wr_ready_o); // R8
endmodule

// File: rtl/sfm_engine.sv
module sfm_engine
  import sfm_pkg::*;
#(
  parameter int FRAME_W    = 8,
  parameter int PORCH_CLKS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_valid_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_pop_o,
  input  logic               rx_full_i,
  output logic               rx_push_o,
  output logic [FRAME_W-1:0] rx_data_o,
  input  logic               miso_i,
  output logic               sck_o,
  output logic               mosi_o,
  output logic               cs_no
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int PC_W  = (PORCH_CLKS > 1) ? $clog2(PORCH_CLKS) : 1;

  sfm_state_e         state_q;
  logic [1:0]         ph_q;
  logic [BIT_W-1:0]   bit_q;
  logic [PC_W-1:0]    porch_q;
  logic [FRAME_W-1:0] tx_sh_q, rx_sh_q;
  logic               last_bit, byte_done, porch_end;

  assign last_bit  = (state_q == ST_BIT) && (ph_q == 2'd3) && (bit_q == '0);
  assign byte_done = last_bit || (state_q == ST_STALL);
  assign porch_end = (porch_q == PC_W'(PORCH_CLKS - 1));
  assign rx_push_o = byte_done && !rx_full_i;
  assign tx_pop_o  = tx_valid_i && ((state_q == ST_IDLE) || rx_push_o);
  assign rx_data_o = rx_sh_q;

  assign sck_o  = (state_q == ST_BIT) && ph_q[1];
  assign mosi_o = (state_q == ST_BIT) && tx_sh_q[FRAME_W-1];
  assign cs_no  = !((state_q == ST_BIT) || (state_q == ST_STALL) || (state_q == ST_BACK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_GAP;
      ph_q    <= '0;
      bit_q   <= '0;
      porch_q <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      unique case (state_q)
        ST_GAP, ST_BACK: begin
          if (porch_end) begin
            porch_q <= '0;
            state_q <= (state_q == ST_GAP) ? ST_IDLE : ST_GAP;
          end else begin
            porch_q <= porch_q + 1'b1;
          end
        end
        ST_BIT: begin
          if (ph_q == 2'd2) rx_sh_q <= {rx_sh_q[FRAME_W-2:0], miso_i};
          if (ph_q != 2'd3) begin
            ph_q <= ph_q + 2'd1;
          end else if (bit_q != '0) begin
            ph_q    <= '0;
            bit_q   <= bit_q - 1'b1;
            tx_sh_q <= tx_sh_q << 1;
          end
        end
        default: ;
      endcase
      if (byte_done) begin
        if (rx_full_i) begin
          state_q <= ST_STALL;
        end else if (!tx_valid_i) begin
          state_q <= ST_BACK;
          porch_q <= '0;
        end
      end
      if (tx_pop_o) begin
        state_q <= ST_BIT;
        tx_sh_q <= tx_data_i;
        ph_q    <= '0;
        bit_q   <= BIT_W'(FRAME_W - 1);
      end
    end
  end

  AST_SCK_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o); // R2
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R3
  AST_CS_MIN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no); // R5
  AST_BACK_PORCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> $past(!sck_o)); // R7
  AST_STALL_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL && rx_full_i) |=> (!sck_o && !cs_no)); // R9
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int FRAME_W    = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int PORCH_CLKS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_valid_i,
  input  logic [FRAME_W-1:0] tx_data_i,
  output logic               tx_ready_o,
  output logic               rx_valid_o,
  output logic [FRAME_W-1:0] rx_data_o,
  input  logic               rx_ready_i,
  output logic               sck_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic               cs_no,
  output logic               busy_o
);
  logic               txq_valid, tx_pop, rxq_ready, rx_push;
  logic [FRAME_W-1:0] txq_data, rx_word;

  sfm_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .wr_valid_i(tx_valid_i), .wr_data_i(tx_data_i), .wr_ready_o(tx_ready_o),
    .rd_valid_o(txq_valid),  .rd_data_o(txq_data),  .rd_ready_i(tx_pop)
  );

  sfm_fifo #(.WIDTH(FRAME_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .wr_valid_i(rx_push),    .wr_data_i(rx_word),   .wr_ready_o(rxq_ready),
    .rd_valid_o(rx_valid_o), .rd_data_o(rx_data_o), .rd_ready_i(rx_ready_i)
  );

  sfm_engine #(.FRAME_W(FRAME_W), .PORCH_CLKS(PORCH_CLKS)) i_engine (
    .clk_i, .rst_ni,
    .tx_valid_i(txq_valid), .tx_data_i(txq_data), .tx_pop_o(tx_pop),
    .rx_full_i(!rxq_ready), .rx_push_o(rx_push),  .rx_data_o(rx_word),
    .miso_i, .sck_o, .mosi_o, .cs_no
  );

  assign busy_o = !cs_no;

  AST_TX_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> txq_valid); // R8
endmodule

// File: tb/test_spi_fifo_master.sv
module test_spi_fifo_master;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_valid_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       rx_ready_i = 1'b0;
  logic       miso_i;
  logic       tx_ready_o, rx_valid_o, sck_o, mosi_o, cs_no, busy_o;
  logic [7:0] rx_data_o;

  always #4 clk_i = ~clk_i; // 125 MHz

  spi_fifo_master i_spi_fifo_master (
    .clk_i, .rst_ni, .tx_valid_i, .tx_data_i, .tx_ready_o,
    .rx_valid_o, .rx_data_o, .rx_ready_i,
    .sck_o, .mosi_o, .miso_i, .cs_no, .busy_o
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  assign miso_i = lfsr[0];
  always @(negedge clk_i)
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference: 0 gap, 1 idle, 2 shifting, 3 stalled, 4 back porch
  logic [7:0] txq[$], rxq[$];
  int m_st = 0, m_cnt = 0, m_ph = 0, m_bit = 0;
  logic [7:0] m_txb = '0, m_rxb = '0;
  int run = 0, last_run = 0;
  logic prev_cs = 1'b1;

  task automatic m_load();
    m_txb = txq.pop_front();
    m_st = 2; m_ph = 0; m_bit = 7;
  endtask

  task automatic m_step();
    int  tx_sz = txq.size();
    int  rx_sz = rxq.size();
    bit  push_tx = tx_valid_i && (tx_sz < 4);
    bit  pop_rx  = rx_ready_i && (rx_sz > 0);
    bit  done = 0;
    case (m_st)
      0: if (m_cnt == 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
      1: if (tx_sz > 0) m_load();
      2: begin
        if (m_ph == 2) m_rxb = {m_rxb[6:0], miso_i};
        if (m_ph < 3) m_ph++;
        else if (m_bit > 0) begin m_bit--; m_ph = 0; m_txb = m_txb << 1; end
        else done = 1;
      end
      3: done = 1;
      default: if (m_cnt == 1) begin m_st = 0; m_cnt = 0; end else m_cnt++;
    endcase
    if (pop_rx) void'(rxq.pop_front());
    if (done) begin
      if (rx_sz >= 4) m_st = 3;
      else begin
        rxq.push_back(m_rxb);
        if (tx_sz > 0) m_load();
        else begin m_st = 4; m_cnt = 0; end
      end
    end
    if (push_tx) txq.push_back(tx_data_i);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_ph = 0; m_bit = 0; m_txb = '0; m_rxb = '0;
      txq.delete(); rxq.delete();
    end else begin
      m_step();
    end
    #2;
    chk("R5 R6 R7 R9 cs_no", cs_no, (m_st < 2));
    chk("R2 R9 sck_o", sck_o, (m_st == 2 && m_ph >= 2));
    chk("R3 mosi_o", mosi_o, (m_st == 2) && m_txb[7]);
    chk("R11 busy_o", busy_o, !(m_st < 2));
    chk("R8 tx_ready_o", tx_ready_o, (txq.size() < 4));
    chk("R10 rx_valid_o", rx_valid_o, (rxq.size() > 0));
    if (rxq.size() > 0) chk("R4 R10 rx_data_o", rx_data_o, rxq[0]);
    if (!cs_no) run++;
    if (cs_no && !prev_cs) begin last_run = run; run = 0; end
    prev_cs = cs_no;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic send(input logic [7:0] d);
    @(negedge clk_i); tx_valid_i = 1'b1; tx_data_i = d;
    @(negedge clk_i); tx_valid_i = 1'b0;
  endtask

  task automatic send_burst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tx_valid_i = 1'b1; tx_data_i = base + 8'(i * 37);
    end
    @(negedge clk_i); tx_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (!(m_st == 1 && txq.size() == 0 && rxq.size() == 0)) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset cs_no", cs_no, 1'b1);
    chk("R1 reset sck_o", sck_o, 1'b0);
    chk("R1 reset mosi_o", mosi_o, 1'b0);
    chk("R1 reset busy_o", busy_o, 1'b0);
    chk("R1 reset tx_ready_o", tx_ready_o, 1'b1);
    chk("R1 reset rx_valid_o", rx_valid_o, 1'b0);
    rst_ni = 1'b1;
    rx_ready_i = 1'b1;

    // single byte right after reset: gap then 32 + porch
    send(8'hA5);
    wait_idle();
    chk("R7 single byte cs low clocks", last_run, 34);
    send(8'h00); wait_idle();
    send(8'hFF); wait_idle();
    chk("R7 single byte cs low clocks", last_run, 34);

    // back-to-back stream
    send_burst(3, 8'h81);
    wait_idle();
    chk("R6 three-byte cs low clocks", last_run, 98);

    // overfill tx queue with rx blocked: drops and stall
    rx_ready_i = 1'b0;
    send_burst(7, 8'h3C);
    repeat (250) @(negedge clk_i);
    chk("R9 stalled cs_no", cs_no, 1'b0);
    chk("R9 stalled sck_o", sck_o, 1'b0);
    chk("R10 rx queue full", rx_valid_o, 1'b1);
    rx_ready_i = 1'b1;
    wait_idle();
    chk("R10 rx drained", rx_valid_o, 1'b0);

    // intermittent reads and a late extra write mid-stream
    send_burst(2, 8'h5A);
    repeat (20) @(negedge clk_i);
    send(8'hC3);
    rx_ready_i = 1'b0;
    repeat (60) @(negedge clk_i);
    rx_ready_i = 1'b1;
    wait_idle();
    repeat (5) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule